// File: doc/BRIEF.md
# Serial CRC-24 Attachment with Per-User Identity Masking

This unit sits in a downlink transmit chain in front of the bit scrambler. It receives one transport block as a bit-serial stream, passes every data bit straight through, and follows the data with a 24-bit cyclic redundancy check. The stream may carry at most one block per 2 ms transmission interval, so a serial datapath at a modest clock has ample headroom.

In masked mode, the upper eight check bits are sent as computed. The lower sixteen check bits are each XORed with one bit of a 16-bit user identity, so that only the addressed receiver sees a clean check. In plain mode, all 24 check bits are sent unmodified. The identity and the mode are captured with the first beat of each block. While the check bits are being sent, the input is held off. A block with no data bits is signalled by a single marker beat and still yields the 24 check bits.

Top module: `crc24_id_attach`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: The data bits of a block leave on `out_bit` unchanged and in arrival order. The first output bit of a block carries `out_first`=1 and every other output bit carries 0.
- R3: The check uses the generator D^24+D^23+D^6+D^5+D+1 (taps 0x800063 below the top term), starting from an all-zero register at the block's first beat and fed with data bits in arrival order. Exactly 24 check bits follow the data, highest register bit first. Check bits 1 to 8 are never masked. Only check bit 24 carries `out_last`=1.
- R4: With `mask_en`=1, check bit 8+j (j=1..16) is XORed with `ue_id[16-j]`, so `ue_id[15]` meets check bit 9 and `ue_id[0]` meets check bit 24.
- R5: With `mask_en`=0, all 24 check bits go out unmasked.
- R6: `ue_id` and `mask_en` are sampled on the accepted beat that has `in_first`=1. Changes to them later in the same block do not affect that block's output.
- R7: From the cycle after the block's `in_last` beat is accepted until the last check bit has entered the output register, `in_ready` is low.
- R8: A beat with `in_first`=`in_last`=`in_nodata`=1 is a zero-length block. It emits no data bit and emits 24 check bits: 8 zeros followed by the identity in masked mode, or 24 zeros in plain mode. The first of these bits carries `out_first` and the last carries `out_last`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit`, `out_first` and `out_last` hold their values, and no bit is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mask_en | input | 1 | 1 selects masked check bits, 0 selects plain check bits; sampled on the first beat |
| ue_id | input | 16 | User identity used as the mask; sampled on the first beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with `in_valid` |
| in_bit | input | 1 | Input data bit |
| in_first | input | 1 | Beat is the first of a block |
| in_last | input | 1 | Beat is the last of a block |
| in_nodata | input | 1 | Beat carries no data bit (zero-length block marker) |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream takes the output bit when high together with `out_valid` |
| out_bit | output | 1 | Output bit (data, then check bits) |
| out_first | output | 1 | Output bit is the first of a block |
| out_last | output | 1 | Output bit is the final check bit of a block |

## Verification
The assertions assume well-formed framing. Every block opens with an `in_first` beat and closes with exactly one `in_last` beat, and `in_nodata` appears only on a beat that is both first and last. The stimulus builds each block from a length and a mode, so it never emits a stray marker. It varies `in_valid` gaps and `out_ready` stalls freely, which only exercises the handshake rules. It also flips `ue_id` and `mask_en` after the first beat of every block, to show that the sampled copy is the one used.

// File: rtl/crc24_att_pkg.sv
`timescale 1ns/1ps
package crc24_att_pkg;

  typedef enum logic {
    ST_BODY = 1'b0,
    ST_TAIL = 1'b1
  } att_state_e;

endpackage

// File: rtl/crc24_rst_sync.sv
`timescale 1ns/1ps
module crc24_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/crc24_lfsr.sv
`timescale 1ns/1ps
module crc24_lfsr #(
  parameter int           W    = 24,
  parameter logic [W-1:0] POLY = 24'h800063
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic din_i,
  output logic msb_o,
  output logic zero_o
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic [W-1:0] base;
  logic [W-1:0] step;
  logic         fb;
  logic         en;

  assign base = clr_i ? '0 : crc_q;
  assign fb   = din_i ^ base[W-1];

  // one serial division step; taps chosen per bit by the polynomial
  for (genvar g = 0; g < W; g++) begin : g_tap
    if (g == 0) begin : g_lsb
      if (POLY[0]) begin : g_on
        assign step[0] = fb;
      end else begin : g_off
        assign step[0] = 1'b0;
      end
    end else begin : g_up
      if (POLY[g]) begin : g_on
        assign step[g] = base[g-1] ^ fb;
      end else begin : g_off
        assign step[g] = base[g-1];
      end
    end
  end

  always_comb begin
    en = clr_i | upd_i | shift_i;
    if (upd_i)        crc_d = step;
    else if (shift_i) crc_d = {base[W-2:0], 1'b0};
    else              crc_d = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= '0;
    else if (en) crc_q <= crc_d;
  end

  assign msb_o  = crc_q[W-1];
  assign zero_o = (crc_q == '0);

endmodule

// File: rtl/crc24_mask.sv
`timescale 1ns/1ps
module crc24_mask #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            mode_i,
  input  logic            adv_i,
  output logic            mask_o
);

  localparam int AC_W = $clog2(ID_W + 1);

  logic [ID_W-1:0] id_q, id_d;
  logic            mode_q, mode_d;
  logic            en;

  always_comb begin
    en     = load_i | adv_i;
    id_d   = id_q;
    mode_d = mode_q;
    if (load_i) begin
      id_d   = id_i;
      mode_d = mode_i;
    end else if (adv_i) begin
      id_d = {id_q[ID_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      mode_q <= 1'b0;
    end else if (en) begin
      id_q   <= id_d;
      mode_q <= mode_d;
    end
  end

  assign mask_o = mode_q & id_q[ID_W-1];

  // checker: the identity is consumed at most once per bit between loads
  logic [AC_W-1:0] adv_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adv_cnt_q <= '0;
    else if (load_i) adv_cnt_q <= '0;
    else if (adv_i)  adv_cnt_q <= adv_cnt_q + 1'b1;
  end

  AST_MASK_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> (adv_cnt_q < AC_W'(ID_W))); // R4

endmodule

// File: rtl/crc24_ctrl.sv
`timescale 1ns/1ps
module crc24_ctrl
  import crc24_att_pkg::*;
#(
  parameter int CRC_W = 24,
  parameter int ID_W  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid_i,
  input  logic in_bit_i,
  input  logic in_first_i,
  input  logic in_last_i,
  input  logic in_nodata_i,
  output logic in_ready_o,
  input  logic crc_msb_i,
  input  logic mask_bit_i,
  input  logic out_ready_i,
  output logic out_valid_o,
  output logic out_bit_o,
  output logic out_first_o,
  output logic out_last_o,
  output logic crc_clr_o,
  output logic crc_upd_o,
  output logic crc_shift_o,
  output logic crc_din_o,
  output logic id_load_o,
  output logic id_adv_o,
  output logic in_tail_o
);

  localparam int              CNT_W    = $clog2(CRC_W + 1);
  localparam logic [CNT_W-1:0] CLR_IDX  = CNT_W'(CRC_W - ID_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CRC_W - 1);

  att_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             ov_q, ov_d;
  logic             ob_q, ob_d;
  logic             of_q, of_d;
  logic             ol_q, ol_d;

  logic slot_free, acc, data_push, tail_push, masked_zone, tail_bit, out_load;

  always_comb begin
    slot_free   = !ov_q || out_ready_i;
    in_ready_o  = (st_q == ST_BODY) && slot_free;
    acc         = in_valid_i && in_ready_o;
    data_push   = acc && !in_nodata_i;
    tail_push   = (st_q == ST_TAIL) && slot_free;
    masked_zone = (cnt_q >= CLR_IDX);
    tail_bit    = crc_msb_i ^ (mask_bit_i & masked_zone);
    out_load    = data_push | tail_push;
  end

  assign crc_clr_o   = acc && in_first_i;
  assign crc_upd_o   = data_push;
  assign crc_din_o   = in_bit_i;
  assign crc_shift_o = tail_push;
  assign id_load_o   = acc && in_first_i;
  assign id_adv_o    = tail_push && masked_zone;
  assign in_tail_o   = (st_q == ST_TAIL);

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (acc && in_last_i) begin
      st_d  = ST_TAIL;
      cnt_d = '0;
    end
    if (acc && in_first_i && in_nodata_i) pend_d = 1'b1;
    if (tail_push) begin
      cnt_d  = cnt_q + 1'b1;
      pend_d = 1'b0;
      if (cnt_q == LAST_IDX) st_d = ST_BODY;
    end
  end

  // output register next values
  always_comb begin
    ov_d = ov_q && !out_ready_i;
    ob_d = ob_q;
    of_d = of_q;
    ol_d = ol_q;
    if (data_push) begin
      ov_d = 1'b1;
      ob_d = in_bit_i;
      of_d = in_first_i;
      ol_d = 1'b0;
    end else if (tail_push) begin
      ov_d = 1'b1;
      ob_d = tail_bit;
      of_d = pend_q;
      ol_d = (cnt_q == LAST_IDX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BODY;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      ov_q   <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_q <= 1'b0;
      of_q <= 1'b0;
      ol_q <= 1'b0;
    end else if (out_load) begin
      ob_q <= ob_d;
      of_q <= of_d;
      ol_q <= ol_d;
    end
  end

  assign out_valid_o = ov_q;
  assign out_bit_o   = ob_q;
  assign out_first_o = of_q;
  assign out_last_o  = ol_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o)
      && $stable(out_first_o) && $stable(out_last_o))); // R9

  AST_HOLD_OFF_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_last_i) |=> !in_ready_o); // R7

  AST_LAST_FROM_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o && out_last_o) |-> $past(st_q == ST_TAIL)); // R3

endmodule

// File: rtl/crc24_id_attach.sv
`timescale 1ns/1ps
module crc24_id_attach #(
  parameter int               CRC_W = 24,
  parameter int               ID_W  = 16,
  parameter logic [CRC_W-1:0] POLY  = 24'h800063
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_en,
  input  logic [ID_W-1:0] ue_id,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  input  logic            in_first,
  input  logic            in_last,
  input  logic            in_nodata,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_bit,
  output logic            out_first,
  output logic            out_last
);

  logic rst_n_s;
  logic crc_clr, crc_upd, crc_shift, crc_din, crc_msb, crc_zero;
  logic id_load, id_adv, mask_bit, in_tail;

  crc24_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  crc24_lfsr #(.W(CRC_W), .POLY(POLY)) lfsr_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_i   (crc_clr),
    .upd_i   (crc_upd),
    .shift_i (crc_shift),
    .din_i   (crc_din),
    .msb_o   (crc_msb),
    .zero_o  (crc_zero)
  );

  crc24_mask #(.ID_W(ID_W)) mask_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (id_load),
    .id_i   (ue_id),
    .mode_i (mask_en),
    .adv_i  (id_adv),
    .mask_o (mask_bit)
  );

  crc24_ctrl #(.CRC_W(CRC_W), .ID_W(ID_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .in_valid_i  (in_valid),
    .in_bit_i    (in_bit),
    .in_first_i  (in_first),
    .in_last_i   (in_last),
    .in_nodata_i (in_nodata),
    .in_ready_o  (in_ready),
    .crc_msb_i   (crc_msb),
    .mask_bit_i  (mask_bit),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_bit_o   (out_bit),
    .out_first_o (out_first),
    .out_last_o  (out_last),
    .crc_clr_o   (crc_clr),
    .crc_upd_o   (crc_upd),
    .crc_shift_o (crc_shift),
    .crc_din_o   (crc_din),
    .id_load_o   (id_load),
    .id_adv_o    (id_adv),
    .in_tail_o   (in_tail)
  );

  // after all check bits are shifted out the register must be empty
  AST_CRC_DRAINED: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(in_tail) |-> crc_zero); // R3

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !out_valid); // R1

endmodule

// File: tb/crc24_id_attach_tb_top.sv
`timescale 1ns/1ps
module crc24_id_attach_tb_top;

  localparam int MAXL = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mask_en, in_valid, in_bit, in_first, in_last, in_nodata, out_ready;
  logic [15:0] ue_id;
  logic        in_ready, out_valid, out_bit, out_first, out_last;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  crc24_id_attach dut_i (
    .clk(clk), .rst_n(rst_n), .mask_en(mask_en), .ue_id(ue_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .in_first(in_first), .in_last(in_last), .in_nodata(in_nodata),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_first(out_first), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] crc_ref(input bit d[MAXL], input int len);
    logic [23:0] r = '0;
    for (int i = 0; i < len; i++) begin
      logic fb = d[i] ^ r[23];
      r = {r[22:0], 1'b0};
      if (fb) r = r ^ 24'h800063;
    end
    return r;
  endfunction

  task automatic run_block(input int len, input bit mode, input logic [15:0] id,
                           input bit stall);
    bit d[MAXL];
    bit exp_b[MAXL+24];
    bit got_b[MAXL+24];
    logic [23:0] c;
    int nexp, nbeats, sent, got_n, cyc;
    int flag_err, stall_err, leak, data_err, clr_err, msk_err;
    bit in_done, prev_stall, prev_bit, prev_first, prev_last;

    for (int i = 0; i < MAXL; i++) d[i] = 1'($urandom());
    c    = crc_ref(d, len);
    nexp = len + 24;
    for (int i = 0; i < len; i++) exp_b[i] = d[i];
    for (int i = 0; i < 24; i++) begin
      exp_b[len+i] = c[23-i];
      if (mode && i >= 8) exp_b[len+i] = exp_b[len+i] ^ id[15-(i-8)];
    end
    nbeats = (len == 0) ? 1 : len;
    sent = 0; got_n = 0; cyc = 0;
    flag_err = 0; stall_err = 0; leak = 0;
    in_done = 0; prev_stall = 0; prev_bit = 0; prev_first = 0; prev_last = 0;

    while (got_n < nexp) begin
      @(negedge clk);
      cyc++;
      if (cyc > 2000) begin
        chk(1'b0, "R9", "block watchdog, bits received", got_n, nexp);
        break;
      end
      out_ready = stall ? 1'($urandom_range(0, 2) != 0) : 1'b1;
      in_valid  = (sent < nbeats) && (stall ? 1'($urandom_range(0, 3) != 0) : 1'b1);
      in_bit    = (len == 0) ? 1'b0 : d[(sent < nbeats) ? sent : 0];
      in_first  = (sent == 0);
      in_last   = (sent == nbeats - 1);
      in_nodata = (len == 0);
      if (sent > 0) begin        // R6 perturbation after the first beat
        ue_id   = ~id;
        mask_en = ~mode;
      end else begin
        ue_id   = id;
        mask_en = mode;
      end
      #1;
      if (prev_stall && !(out_valid && out_bit == prev_bit &&
                          out_first == prev_first && out_last == prev_last))
        stall_err++;
      if (in_done && in_ready && got_n < nexp - 1) leak++;
      if (out_valid && out_ready) begin
        got_b[got_n] = out_bit;
        if (out_first != (got_n == 0) || out_last != (got_n == nexp - 1)) flag_err++;
        got_n++;
      end
      if (in_valid && in_ready) begin
        sent++;
        if (sent == nbeats) in_done = 1;
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
      prev_first = out_first;
      prev_last  = out_last;
    end
    @(negedge clk);
    in_valid = 0;

    data_err = 0; clr_err = 0; msk_err = 0;
    for (int i = 0; i < len; i++) if (got_b[i] != exp_b[i]) data_err++;
    for (int i = 0; i < 8; i++)  if (got_b[len+i] != exp_b[len+i]) clr_err++;
    for (int i = 8; i < 24; i++) if (got_b[len+i] != exp_b[len+i]) msk_err++;

    chk(got_n == nexp, "R3", "output bit count", got_n, nexp);
    chk(flag_err == 0, "R2 R3", "first/last flag errors", flag_err, 0);
    if (len > 0) chk(data_err == 0, "R2", "data bit mismatches", data_err, 0);
    chk(clr_err == 0, (len == 0) ? "R8" : "R3", "unmasked check bit mismatches", clr_err, 0);
    chk(msk_err == 0, mode ? "R4 R6" : "R5 R6", "trailing check bit mismatches", msk_err, 0);
    chk(leak == 0, "R7", "in_ready high during check bits", leak, 0);
    if (stall) chk(stall_err == 0, "R9", "stall instability count", stall_err, 0);
  endtask

  initial begin
    rst_n = 0; mask_en = 0; ue_id = '0; in_valid = 0; in_bit = 0;
    in_first = 0; in_last = 0; in_nodata = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // fixed zero-length corner: 8 zeros then identity bits
    run_block(0, 1'b1, 16'hFFFF, 1'b0);   // R8
    run_block(0, 1'b0, 16'hFFFF, 1'b0);   // R8 plain

    for (int st = 0; st < 2; st++)
      for (int m = 0; m < 2; m++)
        for (int len = 0; len <= 40; len++)
          run_block(len, 1'(m), 16'hA5C3 ^ 16'(len * 16'h1357), 1'(st));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 global watchdog: actual %0d expected %0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule